// File: doc/BRIEF.md
# Paged Program Counter and Return Stack

This unit decides which ROM word a small 4-bit processor fetches next. It holds a 9-bit program counter over a ROM of eight 64-word pages. It also holds a two-level return stack and an 8-bit Q latch that receives table data. Every cycle it takes the decoded instruction class of the word at the current address, along with the accumulator nibble, the RAM nibble under the data pointer, a 6-bit in-page target field, the skip flag and the ROM word being read. From these it computes the next address.

Two operations take two cycles: the indirect jump and the indirect table load. In their first cycle the ROM address moves to the word the operation points at. In their second cycle that word is read and the busy output is high. The table load borrows the return stack for those two cycles. Every page-relative and indirect address takes its upper bits from the incremented counter. An operation in the last word of a page therefore reaches into the next page, or into the next group of four pages.

Top module: `nib_pc_sequencer`

## Requirements
- R1: A synchronous active-high reset sets the ROM address to 0 and clears both stack levels, the Q latch and busy. A return issued straight after reset goes to address 0.
- R2: Class code 0 (advance) moves the address to address+1. The count is 9-bit binary, so it crosses page boundaries and 0x1FF is followed by 0x000.
- R3: Class code 1 (page jump) keeps bits 8:6 of address+1 and puts the 6-bit target field into bits 5:0. Placed in the last word of a page, it lands in the next page.
- R4: Class code 2 (call) does the same page jump as code 1. It also pushes: the upper stack level takes address+1 and the lower level takes the old upper level.
- R5: Class code 3 (return) loads the address from the upper stack level and moves the lower level into the upper one. The lower level keeps its value.
- R6: Class code 4 (indirect jump) first moves the address to {bit 8 of address+1, accumulator, RAM nibble}. In the following cycle it replaces bits 7:0 with the ROM word read there, keeping bit 8.
- R7: Class code 5 (table load) pushes address+1 and moves the address to {bit 8 of address+1, accumulator, RAM nibble}. In the following cycle it latches the ROM word into Q and pops the stack. Afterwards the upper level is unchanged and the lower level holds the old upper value, so the old lower value is lost. Q changes in no other cycle.
- R8: Busy is high exactly in the second cycle of codes 4 and 5. In that cycle the class code, the skip flag, the target and both nibbles are ignored.
- R9: With skip high, any class code, including 4 and 5, only advances the address by one. It takes one cycle and changes neither the stack nor Q.
- R10: A code 4 or code 5 operation at 0x0FF reaches the upper 256 words. One at 0x1FF reaches the lower 256 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Decoded instruction class of the current word |
| skip | input | 1 | Current word is being skipped |
| acc | input | 4 | Accumulator nibble |
| mem_nib | input | 4 | RAM nibble at the data pointer |
| arg | input | 6 | In-page target field |
| rom_data | input | 8 | ROM word read at rom_addr |
| rom_addr | output | 9 | ROM address (program counter) |
| q | output | 8 | Q latch |
| busy | output | 1 | Second cycle of an indirect operation |

## Verification
A table load uses the return stack in the same two cycles in which it reads ROM data, so the push, the pop and the Q capture overlap. The bench follows two nested calls with a table load and then two returns. It judges the result from where the returns land: the second return must repeat the first address, showing that the old lower level is gone. Page crossing and indirect addressing also fall in one cycle when an indirect operation sits at 0x0FF or 0x1FF. These cases are judged from the address shown in the busy cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;

    // Decoded instruction classes presented by the decoder
    typedef enum logic [2:0] {
        OP_ADVANCE = 3'd0,
        OP_JUMP    = 3'd1,
        OP_CALL    = 3'd2,
        OP_RET     = 3'd3,
        OP_IJMP    = 3'd4,
        OP_TLOAD   = 3'd5
    } op_e;

    // Sequencer phase: idle, or second cycle of an indirect operation
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_IJMP  = 2'd1,
        PH_TLOAD = 2'd2
    } phase_e;

    // Action chosen for the current cycle
    typedef enum logic [2:0] {
        ACT_INC,
        ACT_PAGE,
        ACT_CALL,
        ACT_RET,
        ACT_IJMP_AIM,
        ACT_IJMP_FILL,
        ACT_TLOAD_AIM,
        ACT_TLOAD_DONE
    } act_e;

    typedef struct packed {
        act_e act;
        logic push;
        logic pop;
        logic q_load;
    } ctl_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  op_e    op,
    input  logic   skip,
    output ctl_t   ctl,
    output logic   busy
);

    phase_e phase_q;
    phase_e phase_d;

    always_comb begin
        ctl = '{act: ACT_INC, push: 1'b0, pop: 1'b0, q_load: 1'b0};
        if (phase_q == PH_IJMP) begin
            ctl.act = ACT_IJMP_FILL;
        end else if (phase_q == PH_TLOAD) begin
            ctl.act    = ACT_TLOAD_DONE;
            ctl.pop    = 1'b1;
            ctl.q_load = 1'b1;
        end else if (!skip) begin
            case (op)
                OP_JUMP:  ctl.act = ACT_PAGE;
                OP_CALL:  begin ctl.act = ACT_CALL;      ctl.push = 1'b1; end
                OP_RET:   begin ctl.act = ACT_RET;       ctl.pop  = 1'b1; end
                OP_IJMP:  ctl.act = ACT_IJMP_AIM;
                OP_TLOAD: begin ctl.act = ACT_TLOAD_AIM; ctl.push = 1'b1; end
                default:  ctl.act = ACT_INC;
            endcase
        end
    end

    always_comb begin
        case (ctl.act)
            ACT_IJMP_AIM:  phase_d = PH_IJMP;
            ACT_TLOAD_AIM: phase_d = PH_TLOAD;
            default:       phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    assign busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/seq_stack.sv
module seq_stack #(
    parameter int W     = 9,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_val,
    output logic [W-1:0] top
);

    logic [W-1:0] lvl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
        logic [W-1:0] from_above;
        logic [W-1:0] from_below;
        if (i == 0) begin : g_first
            assign from_above = push_val;
        end else begin : g_mid
            assign from_above = lvl[i-1];
        end
        if (i == DEPTH - 1) begin : g_last
            assign from_below = lvl[i];
        end else begin : g_inner
            assign from_below = lvl[i+1];
        end
        always_ff @(posedge clk) begin
            if (rst)       lvl[i] <= '0;
            else if (push) lvl[i] <= from_above;
            else if (pop)  lvl[i] <= from_below;
        end
    end

    assign top = lvl[0];

endmodule

// File: rtl/seq_pcmux.sv
module seq_pcmux
    import seq_pkg::*;
#(
    parameter int PC_W   = 9,
    parameter int PAGE_W = 6,
    parameter int NIB_W  = 4,
    localparam int DATA_W = 2 * NIB_W
) (
    input  act_e              act,
    input  logic [PC_W-1:0]   pc,
    input  logic [PC_W-1:0]   inc,
    input  logic [PAGE_W-1:0] arg,
    input  logic [NIB_W-1:0]  acc,
    input  logic [NIB_W-1:0]  mem_nib,
    input  logic [DATA_W-1:0] rom_data,
    input  logic [PC_W-1:0]   stk_top,
    output logic [PC_W-1:0]   pc_next
);

    always_comb begin
        case (act)
            ACT_PAGE, ACT_CALL:
                pc_next = {inc[PC_W-1:PAGE_W], arg};
            ACT_RET, ACT_TLOAD_DONE:
                pc_next = stk_top;
            ACT_IJMP_AIM, ACT_TLOAD_AIM:
                pc_next = {inc[PC_W-1:DATA_W], acc, mem_nib};
            ACT_IJMP_FILL:
                pc_next = {pc[PC_W-1:DATA_W], rom_data};
            default:
                pc_next = inc;
        endcase
    end

endmodule

// File: rtl/nib_pc_sequencer.sv
module nib_pc_sequencer
    import seq_pkg::*;
#(
    parameter int PC_W    = 9,
    parameter int PAGE_W  = 6,
    parameter int NIB_W   = 4,
    parameter int STACK_D = 2,
    localparam int DATA_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op,
    input  logic              skip,
    input  logic [NIB_W-1:0]  acc,
    input  logic [NIB_W-1:0]  mem_nib,
    input  logic [PAGE_W-1:0] arg,
    input  logic [DATA_W-1:0] rom_data,
    output logic [PC_W-1:0]   rom_addr,
    output logic [DATA_W-1:0] q,
    output logic              busy
);

    ctl_t            ctl;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] inc;
    logic [PC_W-1:0] pc_next;
    logic [PC_W-1:0] stk_top;

    assign inc = pc_q + 1'b1;

    seq_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .op   (op_e'(op)),
        .skip (skip),
        .ctl  (ctl),
        .busy (busy)
    );

    seq_stack #(.W(PC_W), .DEPTH(STACK_D)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (ctl.push),
        .pop      (ctl.pop),
        .push_val (inc),
        .top      (stk_top)
    );

    seq_pcmux #(.PC_W(PC_W), .PAGE_W(PAGE_W), .NIB_W(NIB_W)) u_mux (
        .act      (ctl.act),
        .pc       (pc_q),
        .inc      (inc),
        .arg      (arg),
        .acc      (acc),
        .mem_nib  (mem_nib),
        .rom_data (rom_data),
        .stk_top  (stk_top),
        .pc_next  (pc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            q    <= '0;
        end else begin
            pc_q <= pc_next;
            if (ctl.q_load) q <= rom_data;
        end
    end

    assign rom_addr = pc_q;

endmodule

// File: rtl/seq_chk.sv
module seq_chk
    import seq_pkg::*;
#(
    parameter int PC_W   = 9,
    parameter int PAGE_W = 6,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        op,
    input logic              skip,
    input logic [PAGE_W-1:0] arg,
    input logic [PC_W-1:0]   rom_addr,
    input logic [DATA_W-1:0] q,
    input logic              busy,
    input logic [PC_W-1:0]   stk_top
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (rom_addr == '0 && q == '0 && !busy));

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !skip && op == OP_ADVANCE) |=> rom_addr == PC_W'($past(rom_addr) + 1'b1));

    // R3
    page_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !skip && op == OP_JUMP) |=> rom_addr[PAGE_W-1:0] == $past(arg));

    // R5
    return_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !skip && op == OP_RET) |=> rom_addr == $past(stk_top));

    // R6
    ijmp_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !skip && op == OP_IJMP) |=> busy);

    // R7
    q_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(q));

    // R8
    busy_single_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R9
    skip_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && skip) |=> (!busy && rom_addr == PC_W'($past(rom_addr) + 1'b1) && $stable(stk_top)));

endmodule

bind nib_pc_sequencer seq_chk #(.PC_W(PC_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .skip     (skip),
    .arg      (arg),
    .rom_addr (rom_addr),
    .q        (q),
    .busy     (busy),
    .stk_top  (stk_top)
);

// File: tb/tb_nib_pc_sequencer.sv
module tb_nib_pc_sequencer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op = 3'd0;
    logic       skip = 1'b0;
    logic [3:0] acc = 4'h0;
    logic [3:0] mem_nib = 4'h0;
    logic [5:0] arg = 6'h00;
    logic [7:0] rom_data;
    logic [8:0] rom_addr;
    logic [7:0] q;
    logic       busy;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // Behavioural ROM: word = low address byte + 0x11
    assign rom_data = rom_addr[7:0] + 8'h11;

    nib_pc_sequencer dut (
        .clk(clk), .rst(rst), .op(op), .skip(skip), .acc(acc),
        .mem_nib(mem_nib), .arg(arg), .rom_data(rom_data),
        .rom_addr(rom_addr), .q(q), .busy(busy)
    );

    typedef struct packed {
        logic [2:0] op;
        logic       skp;
        logic [3:0] a;
        logic [3:0] m;
        logic [5:0] arg;
        logic [8:0] pc;
        logic [7:0] q;
        logic       bsy;
        logic       edg;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 4'h0, 4'h0, 6'h00, 9'h001, 8'h00, 1'b0, 1'b0},
        '{3'd1, 1'b0, 4'h0, 4'h0, 6'h3F, 9'h03F, 8'h00, 1'b0, 1'b0},
        '{3'd1, 1'b0, 4'h0, 4'h0, 6'h05, 9'h045, 8'h00, 1'b0, 1'b0},
        '{3'd2, 1'b0, 4'h0, 4'h0, 6'h3F, 9'h07F, 8'h00, 1'b0, 1'b0},
        '{3'd2, 1'b0, 4'h0, 4'h0, 6'h10, 9'h090, 8'h00, 1'b0, 1'b0},
        '{3'd5, 1'b0, 4'h3, 4'hC, 6'h00, 9'h03C, 8'h00, 1'b1, 1'b0},
        '{3'd1, 1'b0, 4'h0, 4'h0, 6'h01, 9'h091, 8'h4D, 1'b0, 1'b0},
        '{3'd3, 1'b0, 4'h0, 4'h0, 6'h00, 9'h080, 8'h4D, 1'b0, 1'b0},
        '{3'd3, 1'b0, 4'h0, 4'h0, 6'h00, 9'h080, 8'h4D, 1'b0, 1'b0},
        '{3'd1, 1'b0, 4'h0, 4'h0, 6'h3F, 9'h0BF, 8'h4D, 1'b0, 1'b0},
        '{3'd4, 1'b1, 4'h1, 4'h1, 6'h00, 9'h0C0, 8'h4D, 1'b0, 1'b0},
        '{3'd1, 1'b0, 4'h0, 4'h0, 6'h3F, 9'h0FF, 8'h4D, 1'b0, 1'b0},
        '{3'd4, 1'b0, 4'h2, 4'h5, 6'h00, 9'h125, 8'h4D, 1'b1, 1'b1},
        '{3'd2, 1'b0, 4'h0, 4'h0, 6'h00, 9'h136, 8'h4D, 1'b0, 1'b0},
        '{3'd5, 1'b0, 4'hF, 4'hF, 6'h00, 9'h1FF, 8'h4D, 1'b1, 1'b0},
        '{3'd3, 1'b0, 4'h0, 4'h0, 6'h00, 9'h137, 8'h10, 1'b0, 1'b0},
        '{3'd5, 1'b1, 4'h7, 4'h7, 6'h00, 9'h138, 8'h10, 1'b0, 1'b0},
        '{3'd1, 1'b0, 4'h0, 4'h0, 6'h3F, 9'h13F, 8'h10, 1'b0, 1'b0},
        '{3'd4, 1'b0, 4'hB, 4'h0, 6'h00, 9'h1B0, 8'h10, 1'b1, 1'b0},
        '{3'd0, 1'b0, 4'h0, 4'h0, 6'h00, 9'h1C1, 8'h10, 1'b0, 1'b0},
        '{3'd1, 1'b0, 4'h0, 4'h0, 6'h3F, 9'h1FF, 8'h10, 1'b0, 1'b0},
        '{3'd4, 1'b0, 4'h1, 4'h2, 6'h00, 9'h012, 8'h10, 1'b1, 1'b1},
        '{3'd0, 1'b0, 4'h0, 4'h0, 6'h00, 9'h023, 8'h10, 1'b0, 1'b0},
        '{3'd0, 1'b0, 4'h0, 4'h0, 6'h00, 9'h024, 8'h10, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] o, input logic s, input logic [3:0] a,
                         input logic [3:0] m, input logic [5:0] g);
        op = o; skip = s; acc = a; mem_nib = m; arg = g;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        string tag;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state while in reset
        check("R1", "addr", int'(rom_addr), 0);
        check("R1", "q", int'(q), 0);
        check("R1", "busy", int'(busy), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].edg)            tag = "R10";
            else if (i > 0 && VECS[i-1].bsy) tag = "R8";
            else if (VECS[i].skp)       tag = "R9";
            else begin
                case (VECS[i].op)
                    3'd1:    tag = "R3";
                    3'd2:    tag = "R4";
                    3'd3:    tag = "R5";
                    3'd4:    tag = "R6";
                    3'd5:    tag = "R7";
                    default: tag = "R2";
                endcase
            end
            drive(VECS[i].op, VECS[i].skp, VECS[i].a, VECS[i].m, VECS[i].arg);
            check(tag, "addr", int'(rom_addr), int'(VECS[i].pc));
            check(tag, "q", int'(q), int'(VECS[i].q));
            check(tag, "busy", int'(busy), int'(VECS[i].bsy));
        end

        // R8: reset during the busy cycle of a table load
        drive(3'd5, 1'b0, 4'h4, 4'h4, 6'h00);
        check("R8", "busy", int'(busy), 1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "addr", int'(rom_addr), 0);
        check("R1", "q", int'(q), 0);
        check("R1", "busy", int'(busy), 0);
        rst = 1'b0;
        // R1: stack cleared, so a return goes to 0
        drive(3'd3, 1'b0, 4'h0, 4'h0, 6'h00);
        check("R1", "ret addr", int'(rom_addr), 0);
        // R4 / R5: call then return lands after the call
        drive(3'd2, 1'b0, 4'h0, 4'h0, 6'h20);
        check("R4", "addr", int'(rom_addr), 9'h020);
        drive(3'd3, 1'b0, 4'h0, 4'h0, 6'h00);
        check("R5", "addr", int'(rom_addr), 9'h001);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule